// File: doc/BRIEF.md
# Condition-Flag Hazard Stall Unit

This block manages the sign and zero condition flags of a six-stage in-order pipeline (a combined fetch/decode stage, three execute stages, memory, writeback) that has no bypass paths. The flags are written only as an instruction leaves the last execute stage. The flag-writing behaviour depends on the instruction class. Arithmetic and compare instructions write both flags. Logical instructions write only the zero flag. All other classes leave the flags unchanged.

Conditional jumps are resolved in the fetch/decode stage from the flag registers. A jump must not read a flag that an older instruction in the execute stages is still going to write. The block therefore widens the pipeline's existing register-hazard stall with a flag-hazard term. That term depends on the jump kind, because jump-if-less reads only the sign flag, while jump-if-greater reads both flags. The taken indication is forced low while the combined stall is high.

Bubbles that the pipeline inserts during a stall enter the execute stages with the no-op class. A bubble therefore never writes a flag and never causes a flag stall.

Top module: `flag_hazard_unit`

## Requirements
- R1: After reset both flags are 0. A jump-if-greater with no flag writer ahead of it is therefore taken, and a jump-if-less is not taken.
- R2: When the last execute stage holds an arithmetic (class 1) or compare (class 3) instruction, the next clock edge loads the sign flag with the result's most significant bit and loads the zero flag with 1 exactly when the result equals 0.
- R3: When the last execute stage holds a logical instruction (class 2), the next clock edge loads only the zero flag from the result, and the sign flag keeps its value.
- R4: No other class in the last execute stage changes either flag. These classes are no-op 0, jump 4, jump-if-less 5, jump-if-greater 6 and memory 7.
- R5: A jump-if-less (class 5) in fetch/decode raises the stall while any execute stage holds an arithmetic or compare instruction. A logical instruction in an execute stage does not stall it.
- R6: A jump-if-greater (class 6) in fetch/decode raises the stall while any execute stage holds an arithmetic, compare or logical instruction.
- R7: An unconditional jump (class 4), or any class in fetch/decode other than 5 and 6, never causes a flag stall.
- R8: The output stall is the incoming register stall ORed with the flag-hazard terms of R5 and R6.
- R9: When no stall is raised, branch-taken is 1 in three cases: an unconditional jump; a jump-if-less with sign = 1; a jump-if-greater with sign = 0 and zero = 0.
- R10: Branch-taken is 0 in every cycle in which the output stall is 1.
- R11: Branch-taken is 0 whenever fetch/decode holds a class other than 4, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_class_i | input | 3 | Instruction class in fetch/decode |
| ex_class_i | input | 3*NUM_EX (9) | Classes in the execute stages; stage k is bits [3k+2:3k], with k=0 the first and the highest k the last |
| ex_last_result_i | input | DATA_W (32) | Result value in the last execute stage |
| reg_stall_i | input | 1 | Stall from the existing register-hazard logic |
| stall_o | output | 1 | Combined stall |
| br_taken_o | output | 1 | Jump in fetch/decode is taken (valid when stall_o is 0) |

## Verification
Some rules are checked by assertions on every cycle. These are: the register stall passing through to the output, gating of branch-taken by the stall, the unconditional jump never waiting on flags, a flag writer in the last execute stage always stalling a dependent jump, and the flag updates for each class, including the sign flag holding across logical instructions. Other behaviour can only be shown by the bench scenarios. This covers the taken decisions that result from a specific order of writers, for example a logical zero result that follows a negative arithmetic result. It also covers the selective stall of jump-if-less behind logical instructions in each execute stage, and the reset values of the flags as seen through the jump outcome.

// File: rtl/flagstall_pkg.sv
package flagstall_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP   = 3'd0,
    CLS_ARITH = 3'd1,
    CLS_LOGIC = 3'd2,
    CLS_CMP   = 3'd3,
    CLS_JMP   = 3'd4,
    CLS_JLT   = 3'd5,
    CLS_JGT   = 3'd6,
    CLS_MEM   = 3'd7
  } op_class_e;

  function automatic logic cls_writes_sign(op_class_e c);
    return (c == CLS_ARITH) || (c == CLS_CMP);
  endfunction

  function automatic logic cls_writes_zero(op_class_e c);
    return (c == CLS_ARITH) || (c == CLS_CMP) || (c == CLS_LOGIC);
  endfunction
endpackage

// File: rtl/flag_file.sv
module flag_file
  import flagstall_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sign_o,
  output logic              zero_o
);
  localparam int MSB = DATA_W - 1;

  op_class_e cls;
  logic      sign_en, zero_en;
  logic      sign_d, zero_d;
  logic      sign_q, zero_q;

  always_comb begin
    cls     = op_class_e'(cls_i);
    sign_en = cls_writes_sign(cls);
    zero_en = cls_writes_zero(cls);
    sign_d  = result_i[MSB];
    zero_d  = (result_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      if (sign_en) sign_q <= sign_d;
      if (zero_en) zero_q <= zero_d;
    end
  end

  assign sign_o = sign_q;
  assign zero_o = zero_q;

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_ARITH || cls_i == CLS_CMP) |=>
      (sign_o == $past(result_i[MSB]) && zero_o == ($past(result_i) == '0)));

  assert_logic_keeps_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_LOGIC) |=> ($stable(sign_o) && zero_o == ($past(result_i) == '0)));

  assert_idle_keeps_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == CLS_NOP || cls_i == CLS_MEM || cls_i == CLS_JMP ||
     cls_i == CLS_JLT || cls_i == CLS_JGT) |=> ($stable(sign_o) && $stable(zero_o)));
endmodule

// File: rtl/flag_hazard_detect.sv
module flag_hazard_detect
  import flagstall_pkg::*;
#(
  parameter int NUM_EX = 3
) (
  input  logic [CLS_W-1:0]        fd_class_i,
  input  logic [NUM_EX*CLS_W-1:0] ex_class_i,
  input  logic                    reg_stall_i,
  output logic                    stall_o
);
  logic [NUM_EX-1:0] sign_pend;
  logic [NUM_EX-1:0] zero_pend;

  for (genvar k = 0; k < NUM_EX; k++) begin : g_stage
    always_comb begin
      sign_pend[k] = cls_writes_sign(op_class_e'(ex_class_i[k*CLS_W +: CLS_W]));
      zero_pend[k] = cls_writes_zero(op_class_e'(ex_class_i[k*CLS_W +: CLS_W]));
    end
  end

  logic any_sign, any_zero, jlt_wait, jgt_wait;

  always_comb begin
    any_sign = |sign_pend;
    any_zero = |zero_pend;
    jlt_wait = (fd_class_i == CLS_JLT) && any_sign;
    jgt_wait = (fd_class_i == CLS_JGT) && (any_sign || any_zero);
    stall_o  = reg_stall_i || jlt_wait || jgt_wait;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import flagstall_pkg::*;
(
  input  logic [CLS_W-1:0] fd_class_i,
  input  logic             sign_i,
  input  logic             zero_i,
  input  logic             stall_i,
  output logic             taken_o
);
  logic cond;

  always_comb begin
    unique case (op_class_e'(fd_class_i))
      CLS_JMP: cond = 1'b1;
      CLS_JLT: cond = sign_i;
      CLS_JGT: cond = !sign_i && !zero_i;
      default: cond = 1'b0;
    endcase
    taken_o = cond && !stall_i;
  end
endmodule

// File: rtl/flag_hazard_unit.sv
module flag_hazard_unit
  import flagstall_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_EX = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              fd_class_i,
  input  logic [NUM_EX*3-1:0]     ex_class_i,
  input  logic [DATA_W-1:0]       ex_last_result_i,
  input  logic                    reg_stall_i,
  output logic                    stall_o,
  output logic                    br_taken_o
);
  localparam int LAST_LSB = (NUM_EX - 1) * CLS_W;

  logic sign_flag, zero_flag;

  flag_file #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .cls_i    (ex_class_i[LAST_LSB +: CLS_W]),
    .result_i (ex_last_result_i),
    .sign_o   (sign_flag),
    .zero_o   (zero_flag)
  );

  flag_hazard_detect #(.NUM_EX(NUM_EX)) u_detect (
    .fd_class_i  (fd_class_i),
    .ex_class_i  (ex_class_i),
    .reg_stall_i (reg_stall_i),
    .stall_o     (stall_o)
  );

  branch_resolve u_branch (
    .fd_class_i (fd_class_i),
    .sign_i     (sign_flag),
    .zero_i     (zero_flag),
    .stall_i    (stall_o),
    .taken_o    (br_taken_o)
  );

  assert_taken_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !br_taken_o);

  assert_reg_stall_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stall_i |-> stall_o);

  assert_jmp_never_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_class_i == CLS_JMP && !reg_stall_i) |-> (!stall_o && br_taken_o));

  assert_jlt_waits_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_class_i == CLS_JLT &&
     (ex_class_i[LAST_LSB +: CLS_W] == CLS_ARITH ||
      ex_class_i[LAST_LSB +: CLS_W] == CLS_CMP)) |-> stall_o);

  assert_jgt_waits_logic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_class_i == CLS_JGT && ex_class_i[LAST_LSB +: CLS_W] == CLS_LOGIC) |-> stall_o);

  assert_non_jump_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_class_i < 3'd4 || fd_class_i == 3'd7) |-> !br_taken_o);
endmodule

// File: tb/flag_hazard_unit_tb.sv
module flag_hazard_unit_tb;
  localparam int DW = 32;
  localparam int NE = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      fd_cls;
  logic [NE*3-1:0] ex_cls;
  logic [DW-1:0]   res;
  logic            rstall;
  logic            stall, taken;

  int n_cmp = 0;
  int n_bad = 0;
  int m_sign, m_zero;
  string ftag;

  always #5 clk = ~clk;

  flag_hazard_unit #(.DATA_W(DW), .NUM_EX(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .fd_class_i(fd_cls), .ex_class_i(ex_cls),
    .ex_last_result_i(res), .reg_stall_i(rstall),
    .stall_o(stall), .br_taken_o(taken)
  );

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic int cls_at(int k);
    return int'(ex_cls[k*3 +: 3]);
  endfunction

  task automatic compare(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b (fd=%0d ex=%h sf=%0d zf=%0d)",
               tag, act, exp, fd_cls, ex_cls, m_sign, m_zero);
    end
  endtask

  // Drive one cycle: set inputs after negedge, check, then advance model for the edge.
  task automatic step(int fd, int e1, int e2, int e3, logic [DW-1:0] r, logic rs);
    int  any_s, any_z, exp_stall, exp_take, c;
    string st, tt;
    @(negedge clk);
    fd_cls = 3'(fd);
    ex_cls = {3'(e3), 3'(e2), 3'(e1)};
    res    = r;
    rstall = rs;
    #1;
    any_s = 0; any_z = 0;
    for (int k = 0; k < NE; k++) begin
      c = cls_at(k);
      if (c == 1 || c == 3) any_s = 1;
      if (c == 1 || c == 2 || c == 3) any_z = 1;
    end
    exp_stall = rs;
    if (fd == 5 && any_s) exp_stall = 1;
    if (fd == 6 && (any_s || any_z)) exp_stall = 1;
    if (exp_stall) exp_take = 0;
    else if (fd == 4) exp_take = 1;
    else if (fd == 5) exp_take = m_sign;
    else if (fd == 6) exp_take = (m_sign == 0 && m_zero == 0);
    else exp_take = 0;
    st = rs ? "R8" : (fd == 5 ? "R5" : (fd == 6 ? "R6" : "R7"));
    tt = exp_stall ? "R10" : ((fd >= 4 && fd <= 6) ? ftag : "R11");
    compare(st, stall, 1'(exp_stall));
    compare(tt, taken, 1'(exp_take));
    c = e3;
    if (c == 1 || c == 3) begin
      m_sign = int'(r[DW-1]);
      m_zero = (r == 0) ? 1 : 0;
    end else if (c == 2) begin
      m_zero = (r == 0) ? 1 : 0;
    end
  endtask

  initial begin
    rst_n = 1'b0; fd_cls = 0; ex_cls = 0; res = 0; rstall = 0;
    m_sign = 0; m_zero = 0; ftag = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset flags observed through jump outcomes
    ftag = "R1";
    step(6, 0, 0, 0, 0, 0);
    step(5, 0, 0, 0, 0, 0);

    // R2: negative arithmetic result sets sign; jump-if-less waits then is taken
    ftag = "R2";
    step(5, 1, 0, 0, 0, 0);
    step(5, 0, 1, 0, 0, 0);
    step(5, 0, 0, 1, 32'h8000_0004, 0);
    step(5, 0, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    // compare with zero result: sign 0, zero 1
    step(0, 0, 0, 3, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    step(5, 0, 0, 0, 0, 0);

    // R3: negative compare, then logic zero result keeps sign
    ftag = "R3";
    step(0, 0, 0, 3, 32'hFFFF_FFFF, 0);
    step(0, 0, 0, 2, 32'h0000_0000, 0);
    step(5, 0, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    // positive arithmetic, then logic nonzero -> greater taken
    step(0, 0, 0, 1, 32'd5, 0);
    step(0, 0, 0, 2, 32'd0, 0);
    step(0, 0, 0, 2, 32'h8000_0000, 0);
    step(6, 0, 0, 0, 0, 0);

    // R5: logical ops in every execute stage do not stall jump-if-less
    ftag = "R9";
    step(5, 2, 0, 0, 0, 0);
    step(5, 0, 2, 0, 0, 0);
    step(5, 0, 0, 2, 32'd7, 0);
    // R6: logical ops do stall jump-if-greater
    step(6, 2, 0, 0, 0, 0);
    step(6, 0, 2, 0, 0, 0);
    step(6, 0, 0, 2, 32'd1, 0);
    step(6, 0, 0, 0, 0, 0);

    // R4: non-writers at last stage leave flags
    ftag = "R4";
    step(0, 0, 0, 7, 32'h8000_0000, 0);
    step(0, 0, 0, 4, 32'h0, 0);
    step(0, 0, 0, 5, 32'h0, 0);
    step(0, 0, 0, 6, 32'h8000_0000, 0);
    step(6, 0, 0, 0, 0, 0);
    step(5, 0, 0, 0, 0, 0);

    // R7 / R8: unconditional jump ignores writers; register stall passes
    ftag = "R9";
    step(4, 1, 3, 2, 32'd3, 0);
    step(4, 1, 3, 2, 32'd3, 1);
    step(0, 1, 1, 1, 32'd9, 0);
    step(1, 0, 0, 0, 0, 1);
    step(6, 0, 0, 0, 0, 1);

    // Random mix, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] r;
      case ($urandom_range(0, 3))
        0: r = '0;
        1: r = 32'h8000_0000 | 32'($urandom_range(0, 255));
        default: r = 32'($urandom_range(1, 1000));
      endcase
      step($urandom_range(3, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), r, ($urandom_range(0, 7) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule